// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Timestamp Counter

This block keeps a free-running up-counter that serves as a timestamp at a nominal 1 MHz. A single-cycle enable, `osc_en`, marks each cycle of a faster oscillator. A fractional prescaler turns those pulses into counter ticks. The tick rate is the oscillator rate multiplied by (D+1)/(V+1). D is the numerator field of the configuration register and V is the denominator field. Each field is stored as its value minus one.

The counter never raises an interrupt and never stops at a limit; it rolls over to zero. Software sees three registers: the read-only count, the prescaler configuration, and a hold control. While the hold control is set, the counter and the prescaler phase are both frozen. The reset configuration gives one tick per twelve oscillator pulses, so the counter runs at 1 MHz from a 12 MHz oscillator with no setup.

Top module: `usec_stamp_top`

## Requirements
- R1: After reset the count reads 0, the configuration reads 0x0000000B and the hold register reads 0. With no register access, the first tick arrives after exactly 12 enabled oscillator cycles.
- R2: The count changes only on a cycle with `osc_en` high, and then by +1 at most.
- R3: The configuration register is at offset 0x04. Bits 15:8 hold D and bits 7:0 hold V. When D < V, N enabled cycles that follow a configuration write give floor(N*(D+1)/(V+1)) ticks.
- R4: When D >= V, every enabled oscillator cycle gives exactly one tick.
- R5: A configuration write resets the prescaler phase to zero. A partly filled phase from before the write therefore never completes a tick.
- R6: Setting bit 0 of the hold register (offset 0x3C) freezes both the count and the prescaler phase. When the bit is cleared, counting resumes from the phase it held.
- R7: The count register (offset 0x00) is read-only. A write to it leaves the count unchanged.
- R8: The count wraps from all ones to zero on the next tick.
- R9: Read data is registered and loads only on a cycle with `reg_rd` high. The configuration reads in bits 15:0 with zeros above it. The hold register reads in bit 0 with zeros above it. Unmapped offsets read as zero.
- R10: A configuration write stores `reg_wdata[15:0]`, and the new value takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per oscillator cycle |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
A prescaler phase that drifts or is not cleared shows up as a tick count that is off by one after a known number of enabled cycles. The bench can see this as soon as the count is read back after a short, predictable burst. A hold that fails to stop the phase is caught a different way. Counting is split around a long frozen interval, and the error shows as a missing or extra tick once the split run ends. Wrap and step errors appear in the first read after the rollover edge. A narrow-count instance makes that edge reachable within a few hundred cycles.

// File: rtl/usec_stamp_pkg.sv
package usec_stamp_pkg;
  localparam int FRAC_W = 8;
  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_CONFIG = 8'h04;
  localparam logic [7:0] OFF_HOLD   = 8'h3C;

  typedef struct packed {
    logic [FRAC_W-1:0] num_m1;
    logic [FRAC_W-1:0] den_m1;
  } frac_cfg_t;

  localparam frac_cfg_t CFG_RESET = '{num_m1: 8'h00, den_m1: 8'h0B};
endpackage

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
  parameter int FRAC_W = 8,
  localparam int ACC_W = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              hold,
  input  logic              clear,
  input  logic [FRAC_W-1:0] num_m1,
  input  logic [FRAC_W-1:0] den_m1,
  output logic              tick,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] num_full, den_full, sum, acc_d;
  logic             advance, over_unity;

  assign num_full   = ACC_W'(num_m1) + 1'b1;
  assign den_full   = ACC_W'(den_m1) + 1'b1;
  assign sum        = acc_q + num_full;
  assign advance    = step_en && !hold && !clear;
  assign over_unity = num_m1 >= den_m1;

  always_comb begin
    acc_d = acc_q;
    tick  = 1'b0;
    if (clear) begin
      acc_d = '0;
    end else if (advance) begin
      if (over_unity) begin
        acc_d = '0;
        tick  = 1'b1;
      end else if (sum >= den_full) begin
        acc_d = sum - den_full;
        tick  = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [COUNT_W-1:0] count_q
);
  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (tick) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/stamp_regs.sv
module stamp_regs
  import usec_stamp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rd,
  input  logic [COUNT_W-1:0] count,
  output frac_cfg_t          cfg_q,
  output logic               hold_q,
  output logic               cfg_wr,
  output logic [DATA_W-1:0]  reg_rdata
);
  logic sel_count, sel_cfg, sel_hold;
  logic [DATA_W-1:0] rd_mux;

  assign sel_count = reg_addr == ADDR_W'(OFF_COUNT);
  assign sel_cfg   = reg_addr == ADDR_W'(OFF_CONFIG);
  assign sel_hold  = reg_addr == ADDR_W'(OFF_HOLD);
  assign cfg_wr    = reg_wr && sel_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RESET;
      hold_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= frac_cfg_t'(reg_wdata[2*FRAC_W-1:0]);
      if (reg_wr && sel_hold) hold_q <= reg_wdata[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_count)     rd_mux = DATA_W'(count);
    else if (sel_cfg)  rd_mux = DATA_W'(cfg_q);
    else if (sel_hold) rd_mux = DATA_W'(hold_q);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/usec_stamp_top.sv
module usec_stamp_top
  import usec_stamp_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int ACC_W = FRAC_W + 2;

  frac_cfg_t          cfg_q;
  logic               hold_q, cfg_wr, tick;
  logic [ACC_W-1:0]   acc_q;
  logic [COUNT_W-1:0] count_q;

  stamp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .count(count_q),
    .cfg_q(cfg_q), .hold_q(hold_q), .cfg_wr(cfg_wr), .reg_rdata(reg_rdata)
  );

  frac_prescaler #(.FRAC_W(FRAC_W)) u_pre (
    .clk(clk), .rst(rst), .step_en(osc_en), .hold(hold_q), .clear(cfg_wr),
    .num_m1(cfg_q.num_m1), .den_m1(cfg_q.den_m1), .tick(tick), .acc_q(acc_q)
  );

  stamp_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count_q(count_q)
  );
endmodule

// File: rtl/usec_stamp_chk.sv
module usec_stamp_chk #(
  parameter int COUNT_W = 32,
  parameter int ACC_W   = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               osc_en,
  input logic               tick,
  input logic               hold_q,
  input logic               cfg_wr,
  input logic [15:0]        cfg_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic [COUNT_W-1:0] count_q
);
  logic [COUNT_W-1:0] count_next;
  assign count_next = count_q + 1'b1;

  // R2: count steps by zero or one
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(count_q) || count_q == $past(count_next)));

  // R2: no oscillator pulse, no change
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> $stable(count_q));

  // R5: configuration write empties the phase
  a_r5_cfg_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> acc_q == '0);

  // R6: hold freezes count and phase
  a_r6_hold_count: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> $stable(count_q));
  a_r6_hold_phase: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !cfg_wr) |=> $stable(acc_q));

  // R3: phase stays below the denominator
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (rst)
    acc_q <= ACC_W'(cfg_q[7:0]));

  // R8: rollover to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && count_q == '1) |=> count_q == '0);
endmodule

bind usec_stamp_top usec_stamp_chk #(.COUNT_W(COUNT_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .tick(tick), .hold_q(hold_q),
  .cfg_wr(cfg_wr), .cfg_q(cfg_q), .acc_q(acc_q), .count_q(count_q)
);

// File: tb/usec_stamp_top_test.sv
module usec_stamp_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, nar_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  usec_stamp_top uut (
    .clk(clk), .rst(rst), .osc_en(osc_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  usec_stamp_top #(.COUNT_W(8)) uut_narrow (
    .clk(clk), .rst(rst), .osc_en(osc_en), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(nar_rdata)
  );

  // {config, enabled cycles, expected ticks}
  localparam logic [47:0] VEC [8] = '{
    {16'h000B, 16'd24,  16'd2},
    {16'h0102, 16'd30,  16'd20},
    {16'h0304, 16'd25,  16'd20},
    {16'h0000, 16'd10,  16'd10},
    {16'h0500, 16'd7,   16'd7},
    {16'h0207, 16'd16,  16'd6},
    {16'h00FF, 16'd300, 16'd1},
    {16'h0203, 16'd9,   16'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dn);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; dn = nar_rdata;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      @(negedge clk); osc_en = 1'b1;
      repeat (n) @(negedge clk);
      osc_en = 1'b0;
    end
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, vn, c0, c1, hold_data;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values and default rate
    rd(8'h00, v, vn); check("R1 count reset", v, 32'h0);
    rd(8'h04, v, vn); check("R1 config reset", v, 32'h0000000B);
    rd(8'h3C, v, vn); check("R1 hold reset", v, 32'h0);
    run(11); rd(8'h00, v, vn); check("R1 no tick after 11", v, 32'h0);
    run(1);  rd(8'h00, v, vn); check("R1 tick at 12", v, 32'h1);

    // R3 R4 R10 vector table
    foreach (VEC[i]) begin
      wr(8'h04, {16'hA5A5, VEC[i][47:32]});
      rd(8'h04, v, vn);
      check("R10 config stored", v, {16'h0, VEC[i][47:32]});
      rd(8'h00, c0, vn);
      run(int'(VEC[i][31:16]));
      rd(8'h00, c1, vn);
      check((VEC[i][47:40] >= VEC[i][39:32]) ? "R4 unity rate" : "R3 fractional rate",
            c1 - c0, {16'h0, VEC[i][15:0]});
    end

    // R5 configuration write drops partial phase
    wr(8'h04, 32'h0000000B);
    rd(8'h00, c0, vn);
    run(11); wr(8'h04, 32'h0000000B); run(11);
    rd(8'h00, c1, vn); check("R5 phase cleared", c1 - c0, 32'h0);

    // R6 hold freezes count and phase
    wr(8'h04, 32'h0000000B);
    rd(8'h00, c0, vn);
    run(6);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd(8'h3C, hold_data, vn); check("R9 hold readback", hold_data, 32'h1);
    run(40);
    rd(8'h00, c1, vn); check("R6 frozen count", c1 - c0, 32'h0);
    wr(8'h3C, 32'h0);
    run(5); rd(8'h00, c1, vn); check("R6 phase kept before", c1 - c0, 32'h0);
    run(1); rd(8'h00, c1, vn); check("R6 phase kept tick", c1 - c0, 32'h1);

    // R7 count write ignored
    rd(8'h00, c0, vn);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, c1, vn); check("R7 count read-only", c1, c0);

    // R9 unmapped read and registered data
    rd(8'h10, v, vn); check("R9 unmapped zero", v, 32'h0);
    rd(8'h04, v, vn);
    @(negedge clk); reg_addr = 8'h10;
    @(negedge clk); check("R9 holds without strobe", reg_rdata, 32'h0000000B);

    // R8 wrap on the narrow instance
    wr(8'h04, 32'h0);
    rd(8'h00, v, vn);
    run(255 - int'(vn[7:0]));
    rd(8'h00, v, vn); check("R8 at all ones", vn, 32'h000000FF);
    run(1);
    rd(8'h00, v, vn); check("R8 wrapped to zero", vn, 32'h0);

    finish_up();
  end
endmodule